// File: doc/BRIEF.md
# Periodic Battery Health Monitor

This block decides when a backup battery is put under a test load, and whether a low-battery warning is shown. While the main supply is reported good, it waits out a recovery delay and then runs a first load test. After that it runs a new load test each time a long interval has passed. During a test the block drives `load_en`, which switches in an external test resistor. On every cycle of the test window it looks at a digital comparator flag, `batt_low`. The analog comparator and the resistor are outside this block.

A low reading in any cycle of a test window sets the warning. The warning then stays set through later periodic tests that pass. Only a passing test run after a power-up clears it. If the supply fails, any test in progress stops at once and scheduling halts. When the supply comes back, the full recovery delay is counted again. The warning is presented as an open-drain style pair: a pad drive enable, and the level the pin takes with its pull-up. Every delay is a parameter in clock ticks, so short values can be used in simulation. The default values assume a 32768 Hz tick clock and match a one-day interval and a one-second test.

Top module: `batt_health_mon`

## Requirements
- R1: While `rst_n` is low, `load_en` is 0, `warn_n` is 1 and `warn_drive` is 0, and the block holds in its unpowered state. No test starts until `power_ok` is seen high after reset.
- R2: `power_ok` may be high at the clock edge that ends an unpowered cycle. Counting from the cycle after that edge, `load_en` stays 0 for RECOVERY_TICKS cycles. It is then 1 for exactly TEST_TICKS cycles, which form the power-up test.
- R3: After any test ends normally, `load_en` is 0 for exactly INTERVAL_TICKS cycles, measured from the end of that test. A periodic test of TEST_TICKS cycles with `load_en` = 1 follows.
- R4: A cycle with `load_en` = 1 and `batt_low` = 1 sets the warning, and the warning is visible on the outputs in the next cycle.
- R5: A periodic test that sees no low sample leaves an active warning set.
- R6: A power-up test runs even while the warning is active. If that test sees no low sample in any of its cycles, the warning is released in the cycle after its last cycle, and not before.
- R7: A power-up test with a low sample in any of its cycles, the last cycle included, leaves the warning set. Periodic testing then continues.
- R8: In any cycle with `power_ok` = 0, `load_en` is 0 in that same cycle. A test in progress is abandoned and the warning state is kept. While power stays low no test runs, and a new full recovery delay is needed before the next power-up test.
- R9: `batt_low` has no effect while `load_en` is 0.
- R10: Warning encoding: active warning gives `warn_drive` = 1 and `warn_n` = 0 (pin pulled low). No warning gives `warn_drive` = 0 and `warn_n` = 1 (pin released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_ok | input | 1 | Main supply within tolerance |
| batt_low | input | 1 | Comparator result, battery below trip level (valid while loaded) |
| load_en | output | 1 | Connect the battery test load |
| warn_n | output | 1 | Warning pin level with pull-up (0 = warning) |
| warn_drive | output | 1 | Pad pull-down enable for the warning pin |

## Verification
`load_en` is a function of state and `power_ok` in the same cycle. It therefore follows a phase change one cycle after the edge that ends the previous phase, and it follows a drop of `power_ok` in the very cycle the drop occurs. The warning is registered, so it appears or clears one cycle after the test cycle that decides it. The bench's driver works out the cycle number at which each result is due, measured from the cycle in which it changes `power_ok` or `batt_low`, and queues the value expected there. The monitor compares each queued value 1 ns after the falling edge of that exact cycle, and it counts any entry it finds overdue as a failure.

// File: rtl/bhm_pkg.sv
package bhm_pkg;

   typedef enum logic [2:0] {
      BHM_NO_POWER    = 3'd0,
      BHM_RECOVER     = 3'd1,
      BHM_PWRUP_TEST  = 3'd2,
      BHM_WAIT        = 3'd3,
      BHM_PERIOD_TEST = 3'd4
   } bhm_state_e;

   function automatic logic bhm_is_test(input bhm_state_e s);
      return (s == BHM_PWRUP_TEST) || (s == BHM_PERIOD_TEST);
   endfunction

endpackage

// File: rtl/bhm_phase_timer.sv
module bhm_phase_timer
   import bhm_pkg::*;
#(
   parameter int unsigned REC_TICKS  = 6554,
   parameter int unsigned TEST_TICKS = 32768,
   parameter int unsigned INTV_TICKS = 32'd2831155200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  bhm_state_e phase,
   output logic       last
);

   localparam int unsigned MAX_AB  = (REC_TICKS > TEST_TICKS) ? REC_TICKS : TEST_TICKS;
   localparam int unsigned MAX_LIM = (MAX_AB > INTV_TICKS) ? MAX_AB : INTV_TICKS;
   localparam int          CNT_W   = (MAX_LIM > 1) ? $clog2(MAX_LIM) : 1;

   generate
      if (REC_TICKS == 0 || TEST_TICKS == 0 || INTV_TICKS == 0) begin : g_bad_limit
         $error("bhm_phase_timer: every phase length must be at least one tick");
      end

      if (MAX_LIM == 1) begin : g_flat
         // every phase lasts one tick: no counter needed
         logic unused_clr;
         assign unused_clr = clr;
         assign last = (phase != BHM_NO_POWER);
      end else begin : g_count
         localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(REC_TICKS - 1);
         localparam logic [CNT_W-1:0] TEST_LAST = CNT_W'(TEST_TICKS - 1);
         localparam logic [CNT_W-1:0] INTV_LAST = CNT_W'(INTV_TICKS - 1);
         localparam logic [CNT_W-1:0] MAX_LAST  = CNT_W'(MAX_LIM - 1);

         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt <= '0;
            else if (clr)    cnt <= '0;
            else if (!last)  cnt <= cnt + 1'b1;
         end

         always_comb begin
            unique case (phase)
               BHM_RECOVER:     last = (cnt == REC_LAST);
               BHM_PWRUP_TEST,
               BHM_PERIOD_TEST: last = (cnt == TEST_LAST);
               BHM_WAIT:        last = (cnt == INTV_LAST);
               default:         last = 1'b0;
            endcase
         end

         // R3: the phase counter never runs past the longest phase
         a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= MAX_LAST);
      end
   endgenerate

endmodule

// File: rtl/bhm_seq.sv
module bhm_seq
   import bhm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       power_ok,
   input  logic       phase_last,
   output bhm_state_e state,
   output logic       tmr_clr,
   output logic       load_en,
   output logic       pwrup_end
);

   bhm_state_e state_nx;

   always_comb begin
      state_nx = state;
      if (!power_ok) begin
         state_nx = BHM_NO_POWER;
      end else begin
         unique case (state)
            BHM_NO_POWER:    state_nx = BHM_RECOVER;
            BHM_RECOVER:     if (phase_last) state_nx = BHM_PWRUP_TEST;
            BHM_PWRUP_TEST:  if (phase_last) state_nx = BHM_WAIT;
            BHM_WAIT:        if (phase_last) state_nx = BHM_PERIOD_TEST;
            BHM_PERIOD_TEST: if (phase_last) state_nx = BHM_WAIT;
            default:         state_nx = BHM_NO_POWER;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= BHM_NO_POWER;
      else        state <= state_nx;
   end

   assign tmr_clr   = (state_nx != state) || (state == BHM_NO_POWER);
   assign load_en   = bhm_is_test(state) && power_ok;
   assign pwrup_end = (state == BHM_PWRUP_TEST) && power_ok && phase_last;

   // R8: a low supply flag sends the sequencer to the unpowered state
   a_r8_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !power_ok |=> state == BHM_NO_POWER);

   // R2: the power-up test is entered only from the recovery wait
   a_r2_retest_after_recovery: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BHM_PWRUP_TEST && $past(state) != BHM_PWRUP_TEST)
         |-> $past(state) == BHM_RECOVER);

   // R3: the load switches on only at the end of a recovery or interval wait
   a_r3_load_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_en) |-> ($past(state) == BHM_RECOVER || $past(state) == BHM_WAIT));

endmodule

// File: rtl/bhm_warn_latch.sv
module bhm_warn_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic test_active,
   input  logic batt_low,
   input  logic pwrup_end,
   output logic warning
);

   logic sample_low;
   logic fail_q;

   assign sample_low = test_active && batt_low;

   // remembers a low sample seen earlier in the current window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            fail_q <= 1'b0;
      else if (!test_active) fail_q <= 1'b0;
      else if (sample_low)   fail_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     warning <= 1'b0;
      else if (sample_low)            warning <= 1'b1;
      else if (pwrup_end && !fail_q)  warning <= 1'b0;
   end

   // R4: a loaded low reading raises the warning on the next cycle
   a_r4_low_sets_warn: assert property (@(posedge clk) disable iff (!rst_n)
      sample_low |=> warning);

   // R5: the warning only falls at the end of a power-up test
   a_r5_clear_only_at_retest: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(warning) |-> $past(pwrup_end));

   // R7: a power-up test with an earlier failure keeps the warning
   a_r7_failed_retest_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (pwrup_end && fail_q) |=> warning);

endmodule

// File: rtl/batt_health_mon.sv
module batt_health_mon
   import bhm_pkg::*;
#(
   parameter int unsigned RECOVERY_TICKS = 6554,
   parameter int unsigned TEST_TICKS     = 32768,
   parameter int unsigned INTERVAL_TICKS = 32'd2831155200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic power_ok,
   input  logic batt_low,
   output logic load_en,
   output logic warn_n,
   output logic warn_drive
);

   generate
      if (RECOVERY_TICKS < 1 || TEST_TICKS < 1 || INTERVAL_TICKS < 1) begin : g_bad_param
         $error("batt_health_mon: tick parameters must be non-zero");
      end
   endgenerate

   bhm_state_e state;
   logic       tmr_clr;
   logic       phase_last;
   logic       pwrup_end;
   logic       warning;

   bhm_phase_timer #(
      .REC_TICKS  (RECOVERY_TICKS),
      .TEST_TICKS (TEST_TICKS),
      .INTV_TICKS (INTERVAL_TICKS)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .phase (state),
      .last  (phase_last)
   );

   bhm_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .power_ok   (power_ok),
      .phase_last (phase_last),
      .state      (state),
      .tmr_clr    (tmr_clr),
      .load_en    (load_en),
      .pwrup_end  (pwrup_end)
   );

   bhm_warn_latch u_warn (
      .clk         (clk),
      .rst_n       (rst_n),
      .test_active (load_en),
      .batt_low    (batt_low),
      .pwrup_end   (pwrup_end),
      .warning     (warning)
   );

   // open-drain style pin: pull low on warning, otherwise release
   assign warn_drive = warning;
   assign warn_n     = ~warning;

   // R8: the load is never connected without main power
   a_r8_no_load_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
      !power_ok |-> !load_en);

   // R2: the load is only connected in one of the two test states
   a_r2_load_in_tests: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> (state == BHM_PWRUP_TEST || state == BHM_PERIOD_TEST));

endmodule

// File: tb/tb_batt_health_mon.sv
module tb_batt_health_mon;

   localparam int unsigned R = 5;
   localparam int unsigned T = 4;
   localparam int unsigned I = 20;

   typedef struct {
      int unsigned cyc;
      bit          load;
      bit          warn;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n;
   logic power_ok;
   logic batt_low;
   logic load_en;
   logic warn_n;
   logic warn_drive;

   int unsigned cyc = 0;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;
   exp_t        q[$];

   always #4 clk = ~clk;   // 125 MHz

   always @(posedge clk) cyc <= cyc + 1;

   batt_health_mon #(
      .RECOVERY_TICKS (R),
      .TEST_TICKS     (T),
      .INTERVAL_TICKS (I)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .power_ok   (power_ok),
      .batt_low   (batt_low),
      .load_en    (load_en),
      .warn_n     (warn_n),
      .warn_drive (warn_drive)
   );

   task automatic expect_at(input int unsigned c, input bit ld, input bit wr, input string tag);
      exp_t e;
      e.cyc = c; e.load = ld; e.warn = wr; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic go(input int unsigned c);
      while (cyc < c) @(negedge clk);
   endtask

   // monitor: pops every item due in this cycle; R10 encoding checked on both pins
   always @(negedge clk) begin
      #1;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (e.cyc != cyc || load_en !== e.load || warn_drive !== e.warn || warn_n !== !e.warn) begin
            fails++;
            $display("FAIL %s: cyc=%0d due=%0d load_en=%0b exp=%0b warn_drive=%0b exp=%0b warn_n=%0b exp=%0b",
                     e.tag, cyc, e.cyc, load_en, e.load, warn_drive, e.warn, warn_n, !e.warn);
         end
      end
   end

   initial begin
      int unsigned b, p, p2, p3, b2, p4, b3;
      rst_n = 1'b0; power_ok = 1'b0; batt_low = 1'b0;
      repeat (3) @(negedge clk);
      expect_at(cyc + 1, 0, 0, "R1 outputs during reset");
      @(negedge clk);
      rst_n = 1'b1;
      expect_at(cyc + 3, 0, 0, "R1 idle without power after reset");
      go(cyc + 4);

      // first power-up, passing test, then a failing periodic test
      b = cyc;
      p = b + R + T + I + 1;
      p2 = p + T + I;
      expect_at(b + 1, 0, 0, "R2 recovery first cycle");
      expect_at(b + R, 0, 0, "R2 recovery last cycle");
      expect_at(b + R + 1, 1, 0, "R2 power-up test start");
      expect_at(b + R + T, 1, 0, "R2 power-up test last cycle");
      expect_at(b + R + T + 1, 0, 0, "R3 interval first cycle");
      expect_at(p - 1, 0, 0, "R3 interval last cycle");
      expect_at(p, 1, 0, "R3 periodic test start");
      expect_at(p + 1, 1, 0, "R4 before low sample takes effect");
      expect_at(p + 2, 1, 1, "R4 low sample sets warning");
      expect_at(p + T, 0, 1, "R3 periodic window length");
      expect_at(p2, 1, 1, "R5 next periodic test runs");
      expect_at(p2 + T, 0, 1, "R5 passing periodic test keeps warning");
      power_ok = 1'b1;
      go(p + 1);
      batt_low = 1'b1;
      @(negedge clk);
      batt_low = 1'b0;

      // power failure in the middle of a periodic test
      p3 = p2 + T + I;
      expect_at(p3, 1, 1, "R8 test running before power loss");
      expect_at(p3 + 1, 0, 1, "R8 power loss drops load same cycle");
      expect_at(p3 + 3, 0, 1, "R8 warning kept after abort");
      expect_at(p3 + 30, 0, 1, "R8 no testing while unpowered");
      go(p3 + 1);
      power_ok = 1'b0;
      go(p3 + 31);

      // power returns: retest with warning active, passes, clears; R9 idle low ignored
      b2 = cyc;
      p4 = b2 + R + T + I + 1;
      expect_at(b2 + R, 0, 1, "R8 full recovery delay before retest");
      expect_at(b2 + R + 1, 1, 1, "R6 retest runs with warning active");
      expect_at(b2 + R + T, 1, 1, "R6 warning held until retest ends");
      expect_at(b2 + R + T + 1, 0, 0, "R6 passing retest clears warning");
      expect_at(b2 + R + T + 6, 0, 0, "R9 low flag outside test ignored");
      expect_at(p4, 1, 0, "R3 periodic test after retest");
      power_ok = 1'b1;
      go(b2 + R + T + 2);
      batt_low = 1'b1;
      go(b2 + R + T + 5);
      batt_low = 1'b0;

      // abort a passing test, then a power-up test failing on its last cycle
      go(p4 + 1);
      power_ok = 1'b0;
      go(p4 + 5);
      b3 = cyc;
      expect_at(b3 + R + T, 1, 0, "R7 retest last cycle before result");
      expect_at(b3 + R + T + 1, 0, 1, "R7 failed retest sets warning");
      expect_at(b3 + R + T + I + 1, 1, 1, "R7 periodic testing continues");
      expect_at(b3 + R + T + I + 2, 1, 1, "R10 warning pin pulled low");
      power_ok = 1'b1;
      go(b3 + R + T);
      batt_low = 1'b1;
      @(negedge clk);
      batt_low = 1'b0;
      go(b3 + R + T + I + 3);
      power_ok = 1'b0;
      expect_at(cyc + 3, 0, 1, "R8 warning held while unpowered");

      while (q.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, pending=%0d expected=0", q.size());
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule